// File: doc/BRIEF.md
# Serial DAC Word Receiver

This block is the device-side serial front end of a 16-bit digital-to-analog converter. A host frames each word by pulling an active-low frame select low. It then clocks the data in on a serial clock and serial data line, most significant bit first. The block samples the data on each falling edge of the serial clock and builds the word in a shift register. When the last bit arrives, it copies the word into an input register and pulses a word-received flag.

The copy from the input register to the DAC data register depends on an active-low load strobe. If the strobe is held low, the DAC data register takes the new word in the cycle the last bit is captured. If the strobe is held high, the word waits in the input register until the strobe falls. All four pins are asynchronous to the system clock. They pass through two-flop synchronizers, and the block detects edges on the synchronized copies. The host may send the word as two byte-sized bursts with an idle gap between them, provided the frame select stays low throughout.

Top module: `dac_serial_rx`

## Requirements
- R1: After reset, dac_word_o is 0 and word_valid_o is 0.
- R2: While frame_n_i is low, each falling edge of sclk_i shifts one sdin_i bit into the word, and the first bit taken is bit 15. Rising edges shift nothing.
- R3: word_valid_o goes high for exactly one system clock cycle when the sixteenth bit of a frame is captured, and at no other time.
- R4: If load_n_i is low when the sixteenth bit is captured, dac_word_o takes the new word in that same update, with no strobe needed.
- R5: If load_n_i is high when the sixteenth bit is captured, dac_word_o keeps its value. On the next falling edge of load_n_i, dac_word_o takes the held word.
- R6: A word sent as two 8-bit bursts with an idle clock gap between them, with frame_n_i kept low, is assembled as if it had been sent in one burst.
- R7: If frame_n_i rises before sixteen bits have arrived, the partial word is discarded. No pulse occurs, neither the input register nor dac_word_o changes, and the next frame starts again from bit 15.
- R8: Falling edges of sclk_i after the sixteenth one in the same frame are ignored until frame_n_i goes high again.
- R9: A strobe after several words that arrived without a strobe transfers the most recent word. A repeated strobe with no new word leaves dac_word_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock from the host; data is sampled on its falling edge |
| sdin_i | input | 1 | Serial data, MSB first |
| frame_n_i | input | 1 | Frame select, active low |
| load_n_i | input | 1 | Load strobe, active low; held low selects automatic update |
| dac_word_o | output | 16 | DAC data register |
| word_valid_o | output | 1 | One-cycle pulse when a full word has been captured |

## Verification
The hardest case to reach from the ports is a partial frame while a deferred word is still waiting. The discarded bits must not leak into the input register, and this only shows at the output when a later strobe transfers the held word. The stimulus first loads a full word with the strobe high, then sends a seven-bit frame and closes it. Only then does it pulse the strobe, and it expects the earlier word. The byte-burst case inserts a long idle gap between two eight-edge bursts, so the bit counter must hold its state across many idle cycles.

// File: rtl/dac_rx_pkg.sv
package dac_rx_pkg;
  localparam int unsigned DEF_WORD_W = 16;
  localparam int unsigned DEF_STAGES = 2;

  // synchronized pin bundle
  typedef struct packed {
    logic sclk;
    logic sdin;
    logic frame_n;
    logic load_n;
  } pins_t;

  localparam pins_t PINS_RST = '{sclk: 1'b0, sdin: 1'b0, frame_n: 1'b1, load_n: 1'b1};
endpackage

// File: rtl/dac_rx_sync.sv
module dac_rx_sync #(
  parameter int unsigned N      = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] ff_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q[g] <= RST_VAL;
        else         ff_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q[g] <= RST_VAL;
        else         ff_q[g] <= ff_q[g-1];
      end
    end
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/dac_rx_shift.sv
module dac_rx_shift #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_s_i,
  input  logic              sdin_s_i,
  input  logic              frame_n_s_i,
  output logic [WORD_W-1:0] word_o,
  output logic              cap_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

  logic              sclk_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] shift_q;
  logic              cap_q;
  logic              sclk_fall;
  logic [WORD_W-1:0] shift_nx;

  assign sclk_fall = sclk_q & ~sclk_s_i;
  assign shift_nx  = {shift_q[WORD_W-2:0], sdin_s_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q  <= 1'b0;
      cnt_q   <= '0;
      shift_q <= '0;
      cap_q   <= 1'b0;
    end else begin
      sclk_q <= sclk_s_i;
      cap_q  <= 1'b0;
      if (frame_n_s_i) begin
        // idle or aborted frame: drop partial bits
        cnt_q   <= '0;
        shift_q <= '0;
      end else if (sclk_fall && cnt_q != FULL) begin
        shift_q <= shift_nx;
        cnt_q   <= cnt_q + CNT_W'(1);
        if (cnt_q == FULL - CNT_W'(1)) cap_q <= 1'b1;
      end
    end
  end

  assign word_o = shift_q;
  assign cap_o  = cap_q;

  a_r3_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_q |=> !cap_q);
  a_r3_pulse_at_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_q |-> (cnt_q == FULL));
  a_r8_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL);
  a_r7_idle_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_n_s_i |=> (cnt_q == '0));
endmodule

// File: rtl/dac_rx_update.sv
module dac_rx_update #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              load_n_s_i,
  output logic [WORD_W-1:0] dac_o
);
  logic              load_q;
  logic              load_fall;
  logic              pend_q;
  logic [WORD_W-1:0] in_q;
  logic [WORD_W-1:0] dac_q;

  assign load_fall = load_q & ~load_n_s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q <= 1'b1;
      pend_q <= 1'b0;
      in_q   <= '0;
      dac_q  <= '0;
    end else begin
      load_q <= load_n_s_i;
      if (cap_i) begin
        in_q <= word_i;
        if (!load_n_s_i) begin
          dac_q  <= word_i;
          pend_q <= 1'b0;
        end else begin
          pend_q <= 1'b1;
        end
      end else if (load_fall && pend_q) begin
        dac_q  <= in_q;
        pend_q <= 1'b0;
      end
    end
  end

  assign dac_o = dac_q;

  a_r4_auto_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_i && !load_n_s_i) |=> (dac_q == $past(word_i)));
  a_r5_defer_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_i && load_n_s_i) |=> $stable(dac_q));
  a_r9_no_pending_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cap_i && !pend_q) |=> $stable(dac_q));
endmodule

// File: rtl/dac_serial_rx.sv
module dac_serial_rx
  import dac_rx_pkg::*;
#(
  parameter int unsigned WORD_W = DEF_WORD_W,
  parameter int unsigned STAGES = DEF_STAGES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdin_i,
  input  logic              frame_n_i,
  input  logic              load_n_i,
  output logic [WORD_W-1:0] dac_word_o,
  output logic              word_valid_o
);
  localparam int unsigned PIN_N = $bits(pins_t);

  pins_t             pins_raw;
  pins_t             pins_s;
  logic [WORD_W-1:0] word;
  logic              cap;

  assign pins_raw = '{sclk: sclk_i, sdin: sdin_i, frame_n: frame_n_i, load_n: load_n_i};

  dac_rx_sync #(
    .N       (PIN_N),
    .STAGES  (STAGES),
    .RST_VAL (PINS_RST)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pins_raw),
    .q_o    (pins_s)
  );

  dac_rx_shift #(.WORD_W(WORD_W)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sclk_s_i    (pins_s.sclk),
    .sdin_s_i    (pins_s.sdin),
    .frame_n_s_i (pins_s.frame_n),
    .word_o      (word),
    .cap_o       (cap)
  );

  dac_rx_update #(.WORD_W(WORD_W)) u_update (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cap_i      (cap),
    .word_i     (word),
    .load_n_s_i (pins_s.load_n),
    .dac_o      (dac_word_o)
  );

  assign word_valid_o = cap;

  a_r1_reset_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!word_valid_o && dac_word_o == '0));
endmodule

// File: tb/dac_serial_rx_tb.sv
module dac_serial_rx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;
  localparam int SETTLE = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sclk = 1'b0;
  logic        sdin = 1'b0;
  logic        frame_n = 1'b1;
  logic        load_n = 1'b1;
  logic [15:0] dac_word;
  logic        word_valid;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  int long_pulses = 0;
  logic valid_prev = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_serial_rx u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .sclk_i       (sclk),
    .sdin_i       (sdin),
    .frame_n_i    (frame_n),
    .load_n_i     (load_n),
    .dac_word_o   (dac_word),
    .word_valid_o (word_valid)
  );

  always @(posedge clk) begin
    if (word_valid) pulses <= pulses + 1;
    if (word_valid && valid_prev) long_pulses <= long_pulses + 1;
    valid_prev <= word_valid;
  end

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_bits(input logic [15:0] data, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sclk = 1'b1; sdin = data[i];
      wait_clk(HALF);
      sclk = 1'b0;
      wait_clk(HALF);
    end
  endtask

  task automatic frame_word(input logic [15:0] data);
    frame_n = 1'b0; wait_clk(HALF);
    send_bits(data, 16);
    wait_clk(SETTLE);
    frame_n = 1'b1; wait_clk(SETTLE);
  endtask

  task automatic strobe();
    load_n = 1'b0; wait_clk(SETTLE);
    load_n = 1'b1; wait_clk(SETTLE);
  endtask

  task automatic t_reset();
    wait_clk(2);
    check("R1 dac after reset", 32'(dac_word), 32'h0);
    check("R1 valid after reset", 32'(word_valid), 32'h0);
  endtask

  task automatic t_auto();
    int p0;
    load_n = 1'b0; wait_clk(SETTLE);
    p0 = pulses;
    frame_word(16'hA5C3);
    check("R4 auto update", 32'(dac_word), 32'hA5C3);
    check("R3 one pulse", 32'(pulses - p0), 32'd1);
    frame_word(16'h8000);
    check("R2 msb first 8000", 32'(dac_word), 32'h8000);
    frame_word(16'h0001);
    check("R2 lsb last 0001", 32'(dac_word), 32'h0001);
  endtask

  task automatic t_deferred();
    int p0;
    load_n = 1'b1; wait_clk(SETTLE);
    p0 = pulses;
    frame_word(16'h1234);
    check("R5 held before strobe", 32'(dac_word), 32'h0001);
    check("R3 pulse deferred", 32'(pulses - p0), 32'd1);
    strobe();
    check("R5 update on strobe", 32'(dac_word), 32'h1234);
  endtask

  task automatic t_bursts();
    load_n = 1'b0; wait_clk(SETTLE);
    frame_n = 1'b0; wait_clk(HALF);
    send_bits(16'h005A, 8);
    wait_clk(60);
    send_bits(16'h0096, 8);
    wait_clk(SETTLE);
    frame_n = 1'b1; wait_clk(SETTLE);
    check("R6 two bursts", 32'(dac_word), 32'h5A96);
  endtask

  task automatic t_abort();
    int p0;
    load_n = 1'b1; wait_clk(SETTLE);
    frame_word(16'hBEEF);
    p0 = pulses;
    frame_n = 1'b0; wait_clk(HALF);
    send_bits(16'h007F, 7);
    wait_clk(SETTLE);
    frame_n = 1'b1; wait_clk(SETTLE);
    check("R7 no pulse on abort", 32'(pulses - p0), 32'd0);
    check("R7 dac unchanged", 32'(dac_word), 32'h5A96);
    strobe();
    check("R7 input register kept", 32'(dac_word), 32'hBEEF);
    load_n = 1'b0; wait_clk(SETTLE);
    frame_word(16'h0F0F);
    check("R7 fresh frame after abort", 32'(dac_word), 32'h0F0F);
  endtask

  task automatic t_extra();
    int p0;
    p0 = pulses;
    frame_n = 1'b0; wait_clk(HALF);
    send_bits(16'hC001, 16);
    send_bits(16'hFFFF, 5);
    wait_clk(SETTLE);
    frame_n = 1'b1; wait_clk(SETTLE);
    check("R8 extra edges ignored", 32'(dac_word), 32'hC001);
    check("R8 single pulse", 32'(pulses - p0), 32'd1);
  endtask

  task automatic t_latest();
    load_n = 1'b1; wait_clk(SETTLE);
    frame_word(16'h1111);
    frame_word(16'h2222);
    check("R9 held before strobe", 32'(dac_word), 32'hC001);
    strobe();
    check("R9 latest word", 32'(dac_word), 32'h2222);
    strobe();
    check("R9 repeat strobe", 32'(dac_word), 32'h2222);
    check("R3 pulse width", 32'(long_pulses), 32'd0);
  endtask

  initial begin
    wait_clk(3);
    rst_ni = 1'b1;
    t_reset();
    t_auto();
    t_deferred();
    t_bursts();
    t_abort();
    t_extra();
    t_latest();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule